// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects an on-chip bus master to an external asynchronous static RAM of 65,536 words of 16 bits. The master raises a request with an address, write data, a write flag and one enable per byte. The controller then runs a fixed sequence of active-low strobes on the memory pins and answers with a one-cycle ready pulse. For a read, the ready pulse carries the returned word.

Every wait is a whole number of clock cycles. Each count is derived at elaboration time from the clock period and the memory's nanosecond limits: access time, write-pulse width and the time the memory keeps driving after release. Because of this, one netlist can serve either speed grade by changing parameters only. The memory's data bus is presented as separate output, output-enable and input signals, and the pad ring ties them together. The controller makes sure its own drivers never overlap the memory's outputs, including the tail the memory keeps driving after a read.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no transfer is running, chip enable, output enable, write enable and both byte strobes are high, the data drivers are off (`mem_dq_oe` = 0) and `host_rdy` is 0.
- R2: A read holds chip enable and output enable low and write enable high for exactly RD_CYC cycles, where RD_CYC = ceil(T_ACC_NS/CLK_NS) + 1 (10 with the defaults). During those cycles it presents `host_addr` on `mem_addr`. It captures `mem_dq_i` at the clock edge that releases the strobes.
- R3: On a read, a byte lane whose enable is 0 returns 8'h00 in `host_rdata`. Bit 0 of the enables is byte [7:0] and bit 1 is byte [15:8]. The strobe `mem_byte_n[i]` is the inverse of enable bit i.
- R4: A write keeps chip enable low for WE_CYC + 2 cycles. Write enable is high for the first cycle, low for WE_CYC = ceil(T_WP_NS/CLK_NS) cycles (7 with the defaults), then high for one final cycle. Output enable stays high throughout, and address and data are driven and stable throughout.
- R5: A write lowers `mem_byte_n[i]` only for lanes whose enable is 1. A lane with enable 0 keeps its previous memory contents.
- R6: The drivers are never on while output enable is low. After a read, the bus stays undriven for TURN_CYC = ceil(T_HZ_NS/CLK_NS) cycles with the device deselected (5 with the defaults), then for one more idle cycle, before a following write drives it. A back-to-back read then write therefore leaves exactly 6 undriven cycles.
- R7: `host_rdy` is high for exactly one cycle per transfer. It rises on the edge that releases the read strobes, or on the edge that deselects the device at the end of a write.
- R8: A request with both byte enables 0 does not lower chip enable, and `host_rdy` pulses in the cycle after the request is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Transfer request, held until `host_rdy` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_rdy | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with `host_rdy` after a read |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_byte_n | output | 2 | Byte strobes, bit 0 = lower, bit 1 = upper, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The bench's memory model drives valid data only after the access window has elapsed, and it drives 8'hEE on any lane whose strobe is high. A read that is cut short, or that captures a disabled lane, therefore returns a visibly wrong word. Full-word transfers at the lowest, highest and a middle address establish the basic sequence and the cycle lengths. Single-lane writes to one word then show whether the unselected byte is preserved. Single-lane reads separate the zeroed lane from the fetched one. A read followed at once by a write measures the undriven gap, and an empty request exposes any strobe activity that should not occur.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RTURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctl_state_e;

  // ceiling division for nanosecond-to-cycle conversion
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [LANES*8-1:0]   wdata_i,
  input  logic                 capture_i,
  input  logic [LANES-1:0]     lane_n_i,
  input  logic [LANES*8-1:0]   dq_i,
  output logic [LANES*8-1:0]   dq_o,
  output logic [LANES*8-1:0]   rdata_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] wq, rq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wq <= '0;
      else if (load_i) wq <= wdata_i[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rq <= '0;
      else if (capture_i) rq <= lane_n_i[g] ? 8'h00 : dq_i[g*8 +: 8];
    end

    assign dq_o[g*8 +: 8]    = wq;
    assign rdata_o[g*8 +: 8] = rq;
  end

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int CNT_W    = 4,
  parameter int RD_CYC   = 10,
  parameter int TURN_CYC = 5,
  parameter int WE_CYC   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic [LANES-1:0] byte_n_o,
  output logic             dq_oe_o,
  output logic             rdy_o
);

  ctl_state_e       state_q, state_d;
  logic             ce_q, ce_d, oe_q, oe_d, we_q, we_d;
  logic [LANES-1:0] byte_q, byte_d;
  logic             dqoe_q, dqoe_d, rdy_q, rdy_d;

  always_comb begin
    state_d    = state_q;
    ce_d       = ce_q;
    oe_d       = oe_q;
    we_d       = we_q;
    byte_d     = byte_q;
    dqoe_d     = dqoe_q;
    rdy_d      = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i && !rdy_q) begin
          if (be_i == '0) begin
            rdy_d = 1'b1;
          end else begin
            accept_o = 1'b1;
            ce_d     = 1'b0;
            byte_d   = ~be_i;
            if (wr_i) begin
              state_d = ST_WSETUP;
              dqoe_d  = 1'b1;
            end else begin
              state_d    = ST_RD;
              oe_d       = 1'b0;
              tmr_load_o = 1'b1;
              tmr_val_o  = CNT_W'(RD_CYC - 1);
            end
          end
        end
      end
      ST_RD: begin
        if (tmr_zero_i) begin
          capture_o  = 1'b1;
          rdy_d      = 1'b1;
          ce_d       = 1'b1;
          oe_d       = 1'b1;
          byte_d     = '1;
          state_d    = ST_RTURN;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(TURN_CYC - 1);
        end
      end
      ST_RTURN: begin
        if (tmr_zero_i) state_d = ST_IDLE;
      end
      ST_WSETUP: begin
        state_d    = ST_WPULSE;
        we_d       = 1'b0;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: begin
        if (tmr_zero_i) begin
          we_d    = 1'b1;
          state_d = ST_WHOLD;
        end
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
        ce_d    = 1'b1;
        byte_d  = '1;
        dqoe_d  = 1'b0;
        rdy_d   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      byte_q  <= '1;
      dqoe_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      byte_q  <= byte_d;
      dqoe_q  <= dqoe_d;
      rdy_q   <= rdy_d;
    end
  end

  assign ce_n_o   = ce_q;
  assign oe_n_o   = oe_q;
  assign we_n_o   = we_q;
  assign byte_n_o = byte_q;
  assign dq_oe_o  = dqoe_q;
  assign rdy_o    = rdy_q;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 8,
  parameter int T_ACC_NS = 70,
  parameter int T_HZ_NS  = 35,
  parameter int T_WP_NS  = 55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_wr,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic [DATA_W/8-1:0]  host_be,
  output logic                 host_rdy,
  output logic [DATA_W-1:0]    host_rdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [DATA_W/8-1:0]  mem_byte_n,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i
);

  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = cdiv(T_ACC_NS, CLK_NS) + 1;
  localparam int TURN_CYC = imax(1, cdiv(T_HZ_NS, CLK_NS));
  localparam int WE_CYC   = imax(1, cdiv(T_WP_NS, CLK_NS));
  localparam int MAX_CYC  = imax(RD_CYC, imax(TURN_CYC, WE_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_ctl_timer #(.W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sram_ctl_seq #(
    .LANES    (LANES),
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WE_CYC   (WE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (host_req),
    .wr_i       (host_wr),
    .be_i       (host_be),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_n_o     (mem_ce_n),
    .oe_n_o     (mem_oe_n),
    .we_n_o     (mem_we_n),
    .byte_n_o   (mem_byte_n),
    .dq_oe_o    (mem_dq_oe),
    .rdy_o      (host_rdy)
  );

  sram_ctl_lanes #(.LANES(LANES)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (accept),
    .wdata_i   (host_wdata),
    .capture_i (capture),
    .lane_n_i  (mem_byte_n),
    .dq_i      (mem_dq_i),
    .dq_o      (mem_dq_o),
    .rdata_o   (host_rdata)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mem_addr <= '0;
    else if (accept)  mem_addr <= host_addr;
  end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int WE_CYC = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rdy,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_byte_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o
);

  logic [7:0] we_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       we_low_q <= '0;
    else if (!mem_we_n && we_low_q != 8'hFF) we_low_q <= we_low_q + 1'b1;
    else if (mem_we_n)                we_low_q <= '0;
  end

  // R1: deselected means every strobe inactive and drivers off
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && (&mem_byte_n) && !mem_dq_oe));

  // R2: output enable is only used for reads
  assert_read_no_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  // R4: setup before the write pulse
  assert_we_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe && !mem_ce_n));

  // R4: hold after the write pulse and minimum pulse length
  assert_we_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)
                         && (we_low_q >= 8'(WE_CYC))));

  // R6: never drive while the memory may be driving
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R7: ready is a single-cycle pulse
  assert_rdy_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |=> !host_rdy);

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LANES  (LANES),
  .WE_CYC (WE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_rdy   (host_rdy),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_byte_n (mem_byte_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_o   (mem_dq_o)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

  localparam int ACC_CYC = 9;   // ceil(70/8): model data valid after this many cycles
  localparam int EXP_RD  = 10;
  localparam int EXP_WE  = 7;
  localparam int EXP_GAP = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_wr, host_rdy;
  logic [15:0] host_addr, host_wdata, host_rdata;
  logic [1:0]  host_be;
  logic [15:0] mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_byte_n;

  always #4 clk = ~clk;

  sram_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be), .host_rdy(host_rdy),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_byte_n(mem_byte_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int tests = 0;
  int fails = 0;

  // ---------------- memory model and monitors ----------------
  logic [15:0] mem [0:255];
  int  acc = 0;
  int  ce_run = 0, last_ce_len = 0;
  int  rd_run = 0, last_rd_len = 0;
  int  we_run = 0, last_we_len = 0;
  int  rdy_run = 0, last_rdy_len = 0;
  bit  gap_run = 0;
  int  gap_cnt = 0, last_gap = -1;
  bit  ce_seen = 0;
  bit  wpend = 0;
  logic [15:0] last_rd_addr, last_wr_addr, wp_addr, wp_data;
  logic [1:0]  last_rd_byte, last_wr_byte, wp_byte;

  wire reading = !mem_ce_n && !mem_oe_n && mem_we_n;
  wire valid   = reading && (acc >= ACC_CYC);
  assign mem_dq_i[7:0]  = (valid && !mem_byte_n[0]) ? mem[mem_addr[7:0]][7:0]  : 8'hEE;
  assign mem_dq_i[15:8] = (valid && !mem_byte_n[1]) ? mem[mem_addr[7:0]][15:8] : 8'hEE;

  always @(negedge clk) begin
    if (reading) begin
      acc = acc + 1; last_rd_addr = mem_addr; last_rd_byte = mem_byte_n;
    end else acc = 0;
    if (!mem_ce_n) begin ce_run++; ce_seen = 1; end
    else if (ce_run > 0) begin last_ce_len = ce_run; ce_run = 0; end
    if (!mem_oe_n) rd_run++;
    else if (rd_run > 0) begin last_rd_len = rd_run; rd_run = 0; end
    if (!mem_ce_n && !mem_we_n) begin
      we_run++; wpend = 1; wp_addr = mem_addr; wp_data = mem_dq_o; wp_byte = mem_byte_n;
      last_wr_addr = mem_addr; last_wr_byte = mem_byte_n;
    end else if (wpend) begin
      last_we_len = we_run; we_run = 0; wpend = 0;
      if (!wp_byte[0]) mem[wp_addr[7:0]][7:0]  = wp_data[7:0];
      if (!wp_byte[1]) mem[wp_addr[7:0]][15:8] = wp_data[15:8];
    end
    if (host_rdy) rdy_run++;
    else if (rdy_run > 0) begin last_rdy_len = rdy_run; rdy_run = 0; end
    if (!mem_oe_n) begin gap_run = 1; gap_cnt = 0; end
    else if (gap_run && mem_dq_oe) begin last_gap = gap_cnt; gap_run = 0; end
    else if (gap_run) gap_cnt++;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_rdy(input string tag, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
    end while (!host_rdy && cyc < 200);
    check(host_rdy, {tag, " ready timeout"}, 32'(host_rdy), 1);
    host_req = 1'b0;
    #1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    int cyc;
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d; host_be = be;
    wait_rdy("R7 write", cyc);
    check(last_we_len == EXP_WE, "R4 we low cycles", 32'(last_we_len), EXP_WE);
    check(last_ce_len == EXP_WE + 2, "R4 ce low cycles", 32'(last_ce_len), EXP_WE + 2);
    check(last_wr_addr == a, "R4 write address", 32'(last_wr_addr), 32'(a));
    check(last_wr_byte == ~be, "R5 write strobes", 32'(last_wr_byte), 32'(~be));
  endtask

  // no wait before the request: used right after a read for the turnaround case
  task automatic do_read(input logic [15:0] a, input logic [1:0] be, input logic [15:0] exp);
    int cyc;
    host_req = 1'b1; host_wr = 1'b0; host_addr = a; host_be = be;
    wait_rdy("R7 read", cyc);
    check(host_rdata == exp, "R2 read data", 32'(host_rdata), 32'(exp));
    check(last_rd_len == EXP_RD, "R2 read strobe cycles", 32'(last_rd_len), EXP_RD);
    check(last_ce_len == EXP_RD, "R2 ce low cycles", 32'(last_ce_len), EXP_RD);
    check(last_rd_addr == a, "R2 read address", 32'(last_rd_addr), 32'(a));
    check(last_rd_byte == ~be, "R3 read strobes", 32'(last_rd_byte), 32'(~be));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(mem_byte_n == 2'b11, "R1 byte strobes", 32'(mem_byte_n), 3);
    check(!mem_dq_oe && !host_rdy, "R1 drivers and ready", {30'd0, mem_dq_oe, host_rdy}, 0);
  endtask

  task automatic t_word;
    do_write(16'h1234, 16'hA55A, 2'b11);
    @(negedge clk); do_read(16'h1234, 2'b11, 16'hA55A);
    check(mem[8'h34] == 16'hA55A, "R4 stored word", 32'(mem[8'h34]), 32'hA55A);
  endtask

  task automatic t_bounds;
    do_write(16'h0000, 16'h1357, 2'b11);
    do_write(16'hFFFF, 16'h2468, 2'b11);
    @(negedge clk); do_read(16'h0000, 2'b11, 16'h1357);
    @(negedge clk); do_read(16'hFFFF, 2'b11, 16'h2468);
  endtask

  task automatic t_byte_write;
    do_write(16'h00A5, 16'h1111, 2'b11);
    do_write(16'h00A5, 16'hCCBB, 2'b01);
    check(mem[8'hA5] == 16'h11BB, "R5 upper kept", 32'(mem[8'hA5]), 32'h11BB);
    do_write(16'h00A5, 16'h77DD, 2'b10);
    check(mem[8'hA5] == 16'h77BB, "R5 lower kept", 32'(mem[8'hA5]), 32'h77BB);
    @(negedge clk); do_read(16'h00A5, 2'b11, 16'h77BB);
  endtask

  task automatic t_byte_read;
    @(negedge clk); do_read(16'h00A5, 2'b01, 16'h00BB);   // R3 upper lane zero
    @(negedge clk); do_read(16'h00A5, 2'b10, 16'h7700);   // R3 lower lane zero
  endtask

  task automatic t_turn;
    @(negedge clk); do_read(16'h1234, 2'b11, 16'hA55A);
    last_gap = -1;
    host_req = 1'b1; host_wr = 1'b1; host_addr = 16'h0040; host_wdata = 16'h0F0F; host_be = 2'b11;
    begin
      int cyc;
      wait_rdy("R6 write after read", cyc);
    end
    check(last_gap == EXP_GAP, "R6 turnaround gap", 32'(last_gap), EXP_GAP);
    check(mem[8'h40] == 16'h0F0F, "R6 write after read data", 32'(mem[8'h40]), 32'h0F0F);
  endtask

  task automatic t_empty;
    int cyc;
    @(negedge clk);
    ce_seen = 0;
    host_req = 1'b1; host_wr = 1'b1; host_addr = 16'h0040; host_wdata = 16'hFFFF; host_be = 2'b00;
    wait_rdy("R8 empty", cyc);
    check(cyc == 1, "R8 ready latency", 32'(cyc), 1);
    repeat (2) @(negedge clk);
    #1;
    check(!ce_seen, "R8 chip enable untouched", 32'(ce_seen), 0);
    check(mem[8'h40] == 16'h0F0F, "R8 memory untouched", 32'(mem[8'h40]), 32'h0F0F);
    check(last_rdy_len == 1, "R7 ready pulse width", 32'(last_rdy_len), 1);
  endtask

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    rst_n = 1'b0; host_req = 1'b0; host_wr = 1'b0;
    host_addr = '0; host_wdata = '0; host_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_word;
    t_bounds;
    t_byte_write;
    t_byte_read;
    t_turn;
    t_empty;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule